// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block captures a parallel word into a chain of stages and then moves it out one bit at a time through a serial output. A complementary serial output is also provided. It runs on one fast system clock. It treats the external shift clock, the clock-inhibit pin and the active-low load pin as slow, asynchronous signals. These three pins are resynchronized into the system-clock domain. The shift clock and the inhibit pin are merged by OR into one gated clock. A rising edge of that gated clock, detected in the system domain, advances the chain by one position.

While the load pin is low, the stages track the parallel inputs on every system clock, whatever the shift clock and inhibit pins are doing. Once load is released, each gated rising edge shifts the chain toward the last stage, and a new bit enters the first stage from the serial input. The data pins are plain levels with no valid/ready handshake. Nothing can apply back-pressure: the shift rate is set by whoever drives the shift clock, and the serial output is a level that the receiver samples after each edge.

Top module: `piso_shift_reg`

## Requirements
- R1: Stage 0 is the first stage and stage N-1 (default N = 8) is the last. A shift moves each stage's value to the next higher index, and `ser_out` always shows stage N-1.
- R2: While `load_n` is low, each stage i takes `par_in[i]` on every system clock, whatever the levels of `shift_clk` and `clk_inhibit`.
- R3: While `load_n` is low, toggling `shift_clk` or `clk_inhibit` produces no shift. After release, the register holds the parallel word present last.
- R4: With `load_n` high and `clk_inhibit` low, a rising edge of `shift_clk` shifts once. Stage 0 takes `ser_in`.
- R5: With `load_n` high and `shift_clk` low, a rising edge of `clk_inhibit` also shifts once.
- R6: With `load_n` high, edges on either pin while the other pin is held high, and any falling edges, leave every stage unchanged.
- R7: `ser_out_n` is always the inverse of `ser_out`.
- R8: If the gated clock rises in the same system cycle that the synchronized `load_n` returns high, no shift occurs.
- R9: Synchronous active-low reset clears every stage to zero and clears the edge history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_in | input | N | Parallel word; bit i feeds stage i |
| ser_in | input | 1 | Serial bit entering stage 0 on a shift |
| load_n | input | 1 | Active-low level load control (asynchronous pin) |
| shift_clk | input | 1 | External shift clock (asynchronous pin) |
| clk_inhibit | input | 1 | Clock inhibit, ORed with shift_clk (asynchronous pin) |
| ser_out | output | 1 | Last stage |
| ser_out_n | output | 1 | Inverse of the last stage |

## Verification
The assertions check the following on every system cycle:
- a load step copies the parallel word;
- a shift step moves every stage up by one and takes the serial bit into stage 0;
- a hold step changes nothing;
- the control logic never issues a shift while load is active, while the gated clock stays high, or on the cycle load is released.

Some behaviour is shown only by the bench's directed scenarios, because it depends on how the external pins are sequenced. This covers shifting by the inhibit pin, blocking while either pin is held high, loading during clock activity, and the release-with-edge corner. In each case the whole register is shifted out and compared against a bench model.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } piso_op_e;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int          W      = 1,
  parameter int          DEPTH  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] ff [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n)      ff[g] <= RST_VAL;
      else if (g == 0) ff[g] <= d;
      else             ff[g] <= ff[(g == 0) ? 0 : g-1];
    end
  end

  assign q = ff[DEPTH-1];
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clk_s,
  input  logic     inh_s,
  input  logic     load_s_n,
  output piso_op_e op
);
  logic gated, gated_prev, load_prev_n, rise;

  assign gated = clk_s | inh_s;
  assign rise  = gated & ~gated_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gated_prev  <= 1'b0;
      load_prev_n <= 1'b1;
    end else begin
      gated_prev  <= gated;
      load_prev_n <= load_s_n;
    end
  end

  always_comb begin
    if (!load_s_n)                op = OP_LOAD;
    else if (rise && load_prev_n) op = OP_SHIFT;
    else                          op = OP_HOLD;
  end

  // R3: no shift while load is active
  a_r3_no_shift_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_s_n |-> op != OP_SHIFT);
  // R6: a gated clock held high never shifts
  a_r6_level_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && $past(gated)) |-> op != OP_SHIFT);
  // R8: release cycle never shifts
  a_r8_release_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (load_s_n && !$past(load_s_n)) |-> op != OP_SHIFT);
endmodule

// File: rtl/piso_chain.sv
module piso_chain
  import piso_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  piso_op_e     op,
  input  logic [N-1:0] par_in,
  input  logic         ser_in,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_stage
    logic prev_bit;
    if (i == 0) begin : g_first
      assign prev_bit = ser_in;
    end else begin : g_rest
      assign prev_bit = q[i-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else begin
        case (op)
          OP_LOAD:  q[i] <= par_in[i];
          OP_SHIFT: q[i] <= prev_bit;
          default:  q[i] <= q[i];
        endcase
      end
    end
  end

  // R2: load copies the parallel word
  a_r2_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_LOAD |=> q == $past(par_in));
  // R4: shift moves toward the last stage, serial bit enters stage 0
  a_r4_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_SHIFT |=> (q[0] == $past(ser_in)) && (q[N-1:1] == $past(q[N-2:0])));
  // R6: hold keeps every stage
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_HOLD |=> $stable(q));
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int N          = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] par_in,
  input  logic         ser_in,
  input  logic         load_n,
  input  logic         shift_clk,
  input  logic         clk_inhibit,
  output logic         ser_out,
  output logic         ser_out_n
);
  localparam int PINS = 3;
  localparam logic [PINS-1:0] PIN_RST = 3'b100;

  logic [PINS-1:0] pins_s;
  logic [N-1:0]    stages;
  piso_op_e        op;

  piso_sync #(.W(PINS), .DEPTH(SYNC_DEPTH), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({load_n, clk_inhibit, shift_clk}),
    .q     (pins_s)
  );

  piso_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_s    (pins_s[0]),
    .inh_s    (pins_s[1]),
    .load_s_n (pins_s[2]),
    .op       (op)
  );

  piso_chain #(.N(N)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .par_in (par_in),
    .ser_in (ser_in),
    .q      (stages)
  );

  assign ser_out   = stages[N-1];
  assign ser_out_n = ~stages[N-1];

  // R9: cleared stages one cycle after reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
    end else if ($past(!rst_n)) begin
      a_r9_reset_clear: assert (stages == '0);
    end
  end
endmodule

// File: tb/piso_shift_reg_tb.sv
module piso_shift_reg_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] par_in = '0;
  logic         ser_in = 1'b0;
  logic         load_n = 1'b1;
  logic         shift_clk = 1'b0;
  logic         clk_inhibit = 1'b0;
  logic         ser_out, ser_out_n;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model = '0;
  logic [7:0]   pattern = 8'hB4;
  int           pat_idx = 0;

  always #10 clk = ~clk;

  piso_shift_reg #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .par_in(par_in), .ser_in(ser_in),
    .load_n(load_n), .shift_clk(shift_clk), .clk_inhibit(clk_inhibit),
    .ser_out(ser_out), .ser_out_n(ser_out_n)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse(input bit use_inh, input bit expect_shift);
    if (use_inh) clk_inhibit = 1'b1; else shift_clk = 1'b1;
    wait_cyc(5);
    if (expect_shift) model = {model[N-2:0], ser_in};
    if (use_inh) clk_inhibit = 1'b0; else shift_clk = 1'b0;
    wait_cyc(5);
  endtask

  task automatic readout(input string req);
    for (int i = 0; i < N; i++) begin
      chk(req, ser_out, model[N-1]);
      chk("R7", ser_out_n, ~model[N-1]);
      ser_in = pattern[pat_idx % 8];
      pat_idx++;
      pulse(1'b0, 1'b1);
    end
    chk(req, ser_out, model[N-1]);
  endtask

  task automatic load(input logic [N-1:0] v);
    par_in = v; load_n = 1'b0;
    wait_cyc(5);
    load_n = 1'b1;
    wait_cyc(5);
    model = v;
  endtask

  task automatic t_reset;
    chk("R9", ser_out, 1'b0);
    chk("R7", ser_out_n, 1'b1);
    model = '0;
    readout("R9");
  endtask

  task automatic t_load_shift;
    for (int k = 0; k < 4; k++) begin
      load(N'($urandom));
      readout("R1 R4");
    end
  endtask

  task automatic t_inhibit_shift;
    load(N'($urandom));
    for (int i = 0; i < 3; i++) begin
      ser_in = i[0];
      pulse(1'b1, 1'b1);
      chk("R5", ser_out, model[N-1]);
    end
    readout("R5");
  endtask

  task automatic t_hold;
    load(N'($urandom));
    shift_clk = 1'b1; wait_cyc(5);
    model = {model[N-2:0], ser_in};
    pulse(1'b1, 1'b0);
    chk("R6", ser_out, model[N-1]);
    shift_clk = 1'b0; wait_cyc(5);
    chk("R6", ser_out, model[N-1]);
    clk_inhibit = 1'b1; wait_cyc(5);
    model = {model[N-2:0], ser_in};
    pulse(1'b0, 1'b0);
    pulse(1'b0, 1'b0);
    clk_inhibit = 1'b0; wait_cyc(5);
    readout("R6");
  endtask

  task automatic t_load_active;
    logic [N-1:0] v2;
    v2 = N'($urandom);
    par_in = N'($urandom); load_n = 1'b0;
    wait_cyc(4);
    pulse(1'b0, 1'b0);
    pulse(1'b1, 1'b0);
    par_in = v2;
    pulse(1'b0, 1'b0);
    load_n = 1'b1; wait_cyc(5);
    model = v2;
    readout("R3");
    shift_clk = 1'b1;
    wait_cyc(3);
    par_in = ~v2; load_n = 1'b0;
    wait_cyc(5);
    chk("R2", ser_out, ~v2[N-1]);
    load_n = 1'b1; wait_cyc(5);
    shift_clk = 1'b0; wait_cyc(5);
    model = ~v2;
    readout("R2");
  endtask

  task automatic t_release_edge;
    par_in = 8'h81; load_n = 1'b0;
    wait_cyc(5);
    load_n = 1'b1; shift_clk = 1'b1;
    wait_cyc(5);
    shift_clk = 1'b0; wait_cyc(5);
    model = 8'h81;
    readout("R8");
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_load_shift();
    t_inhibit_shift();
    t_hold();
    t_load_active();
    t_release_edge();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule